// File: doc/BRIEF.md
# NAND Die Cached Page Program Model

This block is a synthesizable device-side model of the program path of a single NAND die. It watches a flash bus made of one-cycle strobes (command, address, data, read) that share an 8-bit input bus, and it keeps three stores. The first is a cache register for one page. The second is a data register for one page. The third is a small page array. A host loads a page by sending a load command, a column byte, a page byte and the data bytes. It then ends the load with one of two confirm commands. The cached confirm releases the cache after a short cache-busy time, so the next page can load while the array is still programming. The plain confirm holds the die busy until the array program is complete.

Two ready flags show the state of the pipeline. The die-ready flag covers the cache side, and it drives the active-low ready/busy pin. The array-ready flag is high only when nothing is being programmed. A status command returns a status byte that carries both flags, the pass/fail result of the most recent program, and the result of the program before it. A failure-injection input marks the program being confirmed as failed, so that the host's failure handling can be exercised.

A direct array read command is included so that programmed pages can be observed at the ports. It takes no busy time.

Top module: `nand_cache_prog`

## Requirements
- R1: After reset, rb_n is 1, both ready flags are 1, both fail flags are 0, io_out is 00h, and every cache and array byte holds FFh.
- R2: An accepted load command (80h) sets all cache bytes to FFh. The next address strobe gives the column and the one after gives the page. Each data strobe then writes the cache at the current column and advances the column, wrapping at the page end.
- R3: A cached confirm (15h) given after data entry drops die-ready and array-ready in the next cycle. With the array idle, die-ready returns after T_CBSY cycles. Array-ready returns T_PROG cycles after that.
- R4: If a cached confirm arrives while an earlier page is still programming, the cache-to-data copy takes place one cycle after that program completes, or after T_CBSY cycles if that is later. Die-ready returns at the copy.
- R5: A load command is accepted while die-ready is 1 and array-ready is 0, and the new page can be loaded during the running program.
- R6: A plain confirm (10h) holds both flags at 0 from the next cycle until its own program completes. With the array idle, this is T_PROG+1 cycles.
- R7: Command 70h is accepted in any state. From then on io_out shows the live status byte until another command is accepted. The byte has bit 6 = die-ready, bit 5 = array-ready, bit 1 = previous-program fail, bit 0 = current-program fail, and all other bits 0.
- R8: While die-ready is 0, every command other than 70h is ignored, and the status display stays selected.
- R9: rb_n equals die-ready at all times, so it goes low in the cycle after a confirm.
- R10: force_fail is sampled with the confirm. When that program completes, the current-fail bit takes its result and the previous-fail bit takes the old current-fail value. The page is written either way.
- R11: Command 00h, followed by a column strobe and a page strobe, shows the array byte at that column on io_out. Each read strobe advances the column, with wrap.
- R12: Unknown opcodes are ignored, and so is a confirm that does not follow data entry. No state changes and the display is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command strobe; io_in holds the opcode |
| addr_we | input | 1 | Address strobe; io_in holds column or page |
| data_we | input | 1 | Data input strobe |
| rd_en | input | 1 | Read strobe, advances the read column |
| io_in | input | 8 | Shared command/address/data bus |
| force_fail | input | 1 | Marks the program being confirmed as failed |
| io_out | output | 8 | Status byte or array read data |
| rb_n | output | 1 | Ready/busy, low while the die is busy |

## Verification
The hardest condition to reach is a cached confirm arriving while the array is still busy with the previous page. It is the only case where the cache-busy time stretches past T_CBSY and where the previous-fail bit takes a meaningful value. To create it, the stimulus waits for die-ready and then at once loads a second page at a wrapping column and confirms it, all within the program time of the first page. A cycle-accurate reference model in the bench computes the copy and completion cycles from arithmetic on the confirm cycle. Later, plain confirms with and without injected failure drive the two fail bits through both values.

// File: rtl/nand_cp_pkg.sv
package nand_cp_pkg;

    localparam logic [7:0] OP_LOAD   = 8'h80;
    localparam logic [7:0] OP_CACHE  = 8'h15;
    localparam logic [7:0] OP_PAGE   = 8'h10;
    localparam logic [7:0] OP_STATUS = 8'h70;
    localparam logic [7:0] OP_READ   = 8'h00;

    typedef enum logic [2:0] {
        PH_IDLE, PH_COL, PH_ROW, PH_DATA, PH_RCOL, PH_RROW, PH_ROUT
    } bus_phase_e;

    typedef enum logic [1:0] {
        CS_READY, CS_CBUSY, CS_WAIT, CS_PROG
    } cache_state_e;

    typedef struct packed {
        logic rdy;
        logic ardy;
        logic failc;
        logic fail;
    } die_status_t;

    function automatic logic [7:0] status_byte(input die_status_t s);
        return {1'b0, s.rdy, s.ardy, 3'b000, s.failc, s.fail};
    endfunction

endpackage

// File: rtl/nand_bus_decode.sv
module nand_bus_decode
    import nand_cp_pkg::*;
#(
    parameter int COL_W = 3,
    parameter int ROW_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_we,
    input  logic             addr_we,
    input  logic             data_we,
    input  logic             rd_en,
    input  logic [7:0]       io_in,
    input  logic             rdy,
    output logic             cache_clr,
    output logic             cache_we,
    output logic             conf_valid,
    output logic             conf_cached,
    output logic [COL_W-1:0] cur_col,
    output logic [ROW_W-1:0] cur_row,
    output logic             status_sel,
    output logic             read_sel
);

    bus_phase_e       phase;
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;
    logic             stat_q;
    logic             accepted;
    logic             is_confirm;

    always_comb begin
        accepted    = cmd_we && (rdy || io_in == OP_STATUS);
        is_confirm  = (io_in == OP_PAGE) || (io_in == OP_CACHE);
        cache_clr   = accepted && io_in == OP_LOAD;
        conf_valid  = accepted && is_confirm && phase == PH_DATA;
        conf_cached = io_in == OP_CACHE;
        cache_we    = !cmd_we && !addr_we && data_we && phase == PH_DATA;
        cur_col     = col_q;
        cur_row     = row_q;
        status_sel  = stat_q;
        read_sel    = phase == PH_ROUT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            col_q  <= '0;
            row_q  <= '0;
            stat_q <= 1'b0;
        end else if (cmd_we) begin
            if (accepted) begin
                case (io_in)
                    OP_LOAD: begin
                        phase  <= PH_COL;
                        stat_q <= 1'b0;
                    end
                    OP_READ: begin
                        phase  <= PH_RCOL;
                        stat_q <= 1'b0;
                    end
                    OP_PAGE, OP_CACHE: begin
                        if (phase == PH_DATA) begin
                            phase  <= PH_IDLE;
                            stat_q <= 1'b0;
                        end
                    end
                    OP_STATUS: stat_q <= 1'b1;
                    default: ;
                endcase
            end
        end else if (addr_we) begin
            case (phase)
                PH_COL: begin
                    col_q <= io_in[COL_W-1:0];
                    phase <= PH_ROW;
                end
                PH_ROW: begin
                    row_q <= io_in[ROW_W-1:0];
                    phase <= PH_DATA;
                end
                PH_RCOL: begin
                    col_q <= io_in[COL_W-1:0];
                    phase <= PH_RROW;
                end
                PH_RROW: begin
                    row_q <= io_in[ROW_W-1:0];
                    phase <= PH_ROUT;
                end
                default: ;
            endcase
        end else if (data_we && phase == PH_DATA) begin
            col_q <= col_q + 1'b1;
        end else if (rd_en && !stat_q && phase == PH_ROUT) begin
            col_q <= col_q + 1'b1;
        end
    end

    // R8
    busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && !rdy && io_in != OP_STATUS) |=> ($stable(phase) && $stable(stat_q)));

endmodule

// File: rtl/nand_page_store.sv
module nand_page_store #(
    parameter int COL_W = 3,
    parameter int ROW_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             we,
    input  logic [COL_W-1:0] wcol,
    input  logic [7:0]       wdin,
    input  logic             xfer,
    input  logic             commit,
    input  logic [ROW_W-1:0] commit_row,
    input  logic [ROW_W-1:0] rd_row,
    input  logic [COL_W-1:0] rd_col,
    output logic [7:0]       rd_byte
);

    localparam int PAGE  = 1 << COL_W;
    localparam int PAGES = 1 << ROW_W;

    logic [PAGE-1:0][7:0]             cache_q;
    logic [PAGE-1:0][7:0]             data_q;
    logic [PAGES-1:0][PAGE-1:0][7:0]  arr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cache_q <= '1;
            data_q  <= '1;
            arr_q   <= '1;
        end else begin
            if (clr) begin
                cache_q <= '1;
            end else if (we) begin
                cache_q[wcol] <= wdin;
            end
            if (xfer) begin
                data_q <= cache_q;
            end
            if (commit) begin
                arr_q[commit_row] <= data_q;
            end
        end
    end

    assign rd_byte = arr_q[rd_row][rd_col];

    // R3
    cache_to_data_chk: assert property (@(posedge clk) disable iff (rst)
        xfer |=> (data_q == $past(cache_q)));

    // R10
    commit_page_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> (arr_q[$past(commit_row)] == $past(data_q)));

endmodule

// File: rtl/nand_prog_ctrl.sv
module nand_prog_ctrl
    import nand_cp_pkg::*;
#(
    parameter int ROW_W  = 2,
    parameter int T_CBSY = 6,
    parameter int T_PROG = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conf_valid,
    input  logic             conf_cached,
    input  logic [ROW_W-1:0] conf_row,
    input  logic             fail_in,
    output logic             xfer,
    output logic             commit,
    output logic [ROW_W-1:0] commit_row,
    output die_status_t      status
);

    localparam int CB_W = $clog2(T_CBSY + 1);
    localparam int PG_W = $clog2(T_PROG + 1);

    cache_state_e     cs;
    logic [CB_W-1:0]  cb_cnt;
    logic [PG_W-1:0]  pg_cnt;
    logic             arr_busy;
    logic [ROW_W-1:0] pend_row, arr_row;
    logic             pend_fail, arr_fail;
    logic             fail_q, failc_q;
    logic             arr_done;

    always_comb begin
        arr_done   = arr_busy && pg_cnt == '0;
        xfer       = !arr_busy && ((cs == CS_CBUSY && cb_cnt == '0) || cs == CS_WAIT);
        commit     = arr_done;
        commit_row = arr_row;
        status.rdy   = cs == CS_READY;
        status.ardy  = cs == CS_READY && !arr_busy;
        status.failc = failc_q;
        status.fail  = fail_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs        <= CS_READY;
            cb_cnt    <= '0;
            pend_row  <= '0;
            pend_fail <= 1'b0;
        end else begin
            case (cs)
                CS_READY: if (conf_valid) begin
                    cs        <= conf_cached ? CS_CBUSY : CS_WAIT;
                    cb_cnt    <= CB_W'(T_CBSY - 1);
                    pend_row  <= conf_row;
                    pend_fail <= fail_in;
                end
                CS_CBUSY: begin
                    if (cb_cnt != '0) cb_cnt <= cb_cnt - 1'b1;
                    if (xfer) cs <= CS_READY;
                end
                CS_WAIT: if (xfer) cs <= CS_PROG;
                CS_PROG: if (arr_done) cs <= CS_READY;
                default: cs <= CS_READY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arr_busy <= 1'b0;
            pg_cnt   <= '0;
            arr_row  <= '0;
            arr_fail <= 1'b0;
            fail_q   <= 1'b0;
            failc_q  <= 1'b0;
        end else if (xfer) begin
            arr_busy <= 1'b1;
            pg_cnt   <= PG_W'(T_PROG - 1);
            arr_row  <= pend_row;
            arr_fail <= pend_fail;
        end else if (arr_busy) begin
            if (pg_cnt == '0) begin
                arr_busy <= 1'b0;
                fail_q   <= arr_fail;
                failc_q  <= fail_q;
            end else begin
                pg_cnt <= pg_cnt - 1'b1;
            end
        end
    end

    // R3
    confirm_drops_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        conf_valid |=> !status.rdy);

    // R6
    page_wait_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (cs == CS_PROG) |-> arr_busy);

    // R10
    fail_shift_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> (fail_q == $past(arr_fail) && failc_q == $past(fail_q)));

endmodule

// File: rtl/nand_cache_prog.sv
module nand_cache_prog
    import nand_cp_pkg::*;
#(
    parameter int COL_W  = 3,
    parameter int ROW_W  = 2,
    parameter int T_CBSY = 6,
    parameter int T_PROG = 30
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_we,
    input  logic       addr_we,
    input  logic       data_we,
    input  logic       rd_en,
    input  logic [7:0] io_in,
    input  logic       force_fail,
    output logic [7:0] io_out,
    output logic       rb_n
);

    logic             cache_clr, cache_we, conf_valid, conf_cached;
    logic             status_sel, read_sel, xfer, commit;
    logic [COL_W-1:0] cur_col;
    logic [ROW_W-1:0] cur_row, commit_row;
    logic [7:0]       rd_byte;
    die_status_t      st;

    nand_bus_decode #(.COL_W(COL_W), .ROW_W(ROW_W)) u_decode (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .addr_we(addr_we),
        .data_we(data_we), .rd_en(rd_en), .io_in(io_in), .rdy(st.rdy),
        .cache_clr(cache_clr), .cache_we(cache_we), .conf_valid(conf_valid),
        .conf_cached(conf_cached), .cur_col(cur_col), .cur_row(cur_row),
        .status_sel(status_sel), .read_sel(read_sel)
    );

    nand_page_store #(.COL_W(COL_W), .ROW_W(ROW_W)) u_store (
        .clk(clk), .rst(rst), .clr(cache_clr), .we(cache_we),
        .wcol(cur_col), .wdin(io_in), .xfer(xfer), .commit(commit),
        .commit_row(commit_row), .rd_row(cur_row), .rd_col(cur_col),
        .rd_byte(rd_byte)
    );

    nand_prog_ctrl #(.ROW_W(ROW_W), .T_CBSY(T_CBSY), .T_PROG(T_PROG)) u_ctrl (
        .clk(clk), .rst(rst), .conf_valid(conf_valid), .conf_cached(conf_cached),
        .conf_row(cur_row), .fail_in(force_fail), .xfer(xfer), .commit(commit),
        .commit_row(commit_row), .status(st)
    );

    always_comb begin
        rb_n = st.rdy;
        if (status_sel)    io_out = status_byte(st);
        else if (read_sel) io_out = rd_byte;
        else               io_out = 8'h00;
    end

endmodule

// File: tb/nand_cache_prog_bench.sv
module nand_cache_prog_bench;

    localparam int T_CBSY = 6;
    localparam int T_PROG = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_we = 0, addr_we = 0, data_we = 0, rd_en = 0, force_fail = 0;
    logic [7:0] io_in = 8'h00;
    logic [7:0] io_out;
    logic rb_n;

    int tests = 0, fails = 0, wd = 0;
    bit started = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    nand_cache_prog u_nand_cache_prog (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .addr_we(addr_we),
        .data_we(data_we), .rd_en(rd_en), .io_in(io_in),
        .force_fail(force_fail), .io_out(io_out), .rb_n(rb_n)
    );

    // ---------------- reference model (event times as arithmetic) -------
    int n = 0, rdy_back = 0, xfer_at = 0, done_at = 0, last_done = 0;
    int ph = 0, col = 0, row = 0, pend_row = 0, arr_row = 0;
    bit m_rdy = 1, m_ardy = 1, rpre, busy_arr = 0, xfer_pend = 0;
    bit stat = 0, f = 0, fc = 0, pend_f = 0, arr_f = 0;
    byte unsigned m_cache[8], m_dreg[8], m_arr[32];

    always @(posedge clk) begin
        n++;
        if (rst) begin
            rdy_back = 0; m_rdy = 1; m_ardy = 1; busy_arr = 0; xfer_pend = 0;
            ph = 0; col = 0; row = 0; stat = 0; f = 0; fc = 0;
            foreach (m_cache[i]) begin m_cache[i] = 8'hFF; m_dreg[i] = 8'hFF; end
            foreach (m_arr[i]) m_arr[i] = 8'hFF;
        end else begin
            rpre = m_rdy;
            if (busy_arr && n == done_at) begin
                for (int i = 0; i < 8; i++) m_arr[arr_row*8+i] = m_dreg[i];
                fc = f; f = arr_f; busy_arr = 0;
            end
            if (xfer_pend && n == xfer_at) begin
                m_dreg = m_cache; arr_row = pend_row; arr_f = pend_f;
                busy_arr = 1; done_at = n + T_PROG; xfer_pend = 0;
            end
            if (cmd_we) begin
                if (rpre || io_in == 8'h70) begin
                    if (io_in == 8'h80) begin
                        foreach (m_cache[i]) m_cache[i] = 8'hFF;
                        ph = 1; stat = 0;
                    end else if (io_in == 8'h00) begin
                        ph = 4; stat = 0;
                    end else if ((io_in == 8'h10 || io_in == 8'h15) && ph == 3) begin
                        last_done = busy_arr ? done_at : n;
                        if (io_in == 8'h15) begin
                            xfer_at = (n + T_CBSY > last_done + 1) ? n + T_CBSY : last_done + 1;
                            rdy_back = xfer_at;
                        end else begin
                            xfer_at = (n + 1 > last_done + 1) ? n + 1 : last_done + 1;
                            rdy_back = xfer_at + T_PROG;
                        end
                        xfer_pend = 1; pend_row = row; pend_f = force_fail;
                        ph = 0; stat = 0;
                    end else if (io_in == 8'h70) begin
                        stat = 1;
                    end
                end
            end else if (addr_we) begin
                case (ph)
                    1: begin col = io_in % 8; ph = 2; end
                    2: begin row = io_in % 4; ph = 3; end
                    4: begin col = io_in % 8; ph = 5; end
                    5: begin row = io_in % 4; ph = 6; end
                    default: ;
                endcase
            end else if (data_we && ph == 3) begin
                m_cache[col] = io_in; col = (col + 1) % 8;
            end else if (rd_en && !stat && ph == 6) begin
                col = (col + 1) % 8;
            end
            m_rdy = (n >= rdy_back);
            m_ardy = m_rdy && !busy_arr && !xfer_pend;
        end
    end

    function automatic logic [7:0] model_io();
        if (stat) return {1'b0, m_rdy, m_ardy, 3'b000, fc, f};
        if (ph == 6) return m_arr[row*8+col];
        return 8'h00;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h (time %0t)", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk({cur_req, " rb_n/R9"}, {7'd0, rb_n}, {7'd0, m_rdy});
            chk({cur_req, " io_out"}, io_out, model_io());
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            fails++;
            $display("FAIL watchdog: actual no end, expected end by cycle 20000");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic p_cmd(input logic [7:0] v);
        cmd_we = 1; io_in = v; @(negedge clk); cmd_we = 0;
    endtask
    task automatic p_addr(input logic [7:0] v);
        addr_we = 1; io_in = v; @(negedge clk); addr_we = 0;
    endtask
    task automatic p_data(input logic [7:0] v);
        data_we = 1; io_in = v; @(negedge clk); data_we = 0;
    endtask
    task automatic p_rd();
        rd_en = 1; @(negedge clk); rd_en = 0;
    endtask
    task automatic wait_idle();
        p_cmd(8'h70);
        while (io_out[5] !== 1'b1) @(negedge clk);
    endtask

    byte unsigned pg1_exp[8] = '{8'hB3, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hB0, 8'hB1, 8'hB2};

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        started = 1;
        // R1 reset state
        chk("R1", {7'd0, rb_n}, 8'h01);
        chk("R1", io_out, 8'h00);
        cur_req = "R7";
        p_cmd(8'h70);
        chk("R7", io_out, 8'h60);

        // R2 / R3: page 0 via cached confirm on an idle array
        cur_req = "R2";
        p_cmd(8'h80); p_addr(8'h00); p_addr(8'h00);
        for (int i = 0; i < 8; i++) p_data(8'hA0 + 8'(i));
        cur_req = "R3";
        p_cmd(8'h15);
        chk("R9", {7'd0, rb_n}, 8'h00);
        p_cmd(8'h70);
        chk("R7", io_out, 8'h00);
        cur_req = "R8";
        p_cmd(8'h80);
        chk("R8", io_out, 8'h00);
        cur_req = "R3";
        while (rb_n !== 1'b1) @(negedge clk);
        chk("R3", io_out, 8'h40);

        // R5 / R4: load during program, confirm while array busy
        cur_req = "R5";
        p_cmd(8'h80); p_addr(8'h05); p_addr(8'h01);
        for (int i = 0; i < 4; i++) p_data(8'hB0 + 8'(i));
        cur_req = "R4";
        p_cmd(8'h15);
        chk("R4", {7'd0, rb_n}, 8'h00);
        wait_idle();

        // R6 / R10: plain confirm with injected failure
        cur_req = "R6";
        p_cmd(8'h80); p_addr(8'h00); p_addr(8'h02);
        p_data(8'hC0); p_data(8'hC1);
        force_fail = 1;
        p_cmd(8'h10);
        force_fail = 0;
        chk("R6", {7'd0, rb_n}, 8'h00);
        cur_req = "R10";
        wait_idle();
        chk("R10", io_out, 8'h61);

        cur_req = "R6";
        p_cmd(8'h80); p_addr(8'h00); p_addr(8'h03); p_data(8'hD0);
        p_cmd(8'h10);
        cur_req = "R10";
        wait_idle();
        chk("R10", io_out, 8'h62);

        // R12: unknown opcode and stray confirm
        cur_req = "R12";
        p_cmd(8'h3C);
        p_cmd(8'h15);
        chk("R12", {7'd0, rb_n}, 8'h01);
        chk("R12", io_out, 8'h62);

        // R11: read back pages
        cur_req = "R11";
        p_cmd(8'h00); p_addr(8'h00); p_addr(8'h00);
        for (int i = 0; i < 8; i++) begin
            chk("R11", io_out, 8'hA0 + 8'(i));
            p_rd();
        end
        p_cmd(8'h00); p_addr(8'h00); p_addr(8'h01);
        for (int i = 0; i < 8; i++) begin
            chk("R2", io_out, pg1_exp[i]);
            p_rd();
        end
        p_cmd(8'h00); p_addr(8'h01); p_addr(8'h02);
        chk("R10", io_out, 8'hC1);
        repeat (4) @(negedge clk);
        started = 0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule